// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Block

This block is the software-visible front end of a multi-channel memory-access layer that moves network frames for a set of transmit and a set of receive channels. It holds the global configuration, an error status word, an interrupt enable word, and the channel activation set and reset words for each direction. It also holds per-direction status words for end-of-buffer and descriptor-error events, a table pointer per channel, and a buffer-size value per receive channel. All of these sit at fixed addresses on a simple synchronous register bus.

A datapath outside this block reports events as single-cycle pulses. Each pulse sets a status bit. Software clears status bits by writing ones, and five interrupt lines show which enabled status groups are pending. A soft-reset bit in the configuration word returns the control and status words to their reset values. The table pointers and buffer sizes keep their contents across a soft reset.

The channel counts `TX_CH` and `RX_CH` are elaboration parameters from 1 to 32. Channel n is always reported at status bit 31-n.

Top module: `dmar_regs`

## Requirements
- R1: After reset, the configuration word (address 0x180) reads 0x0007C000. Every other register reads zero, and all five interrupt outputs are low.
- R2: A write to 0x180 stores the written value ANDed with 0x00FFC087, so bit 31 always reads back as zero.
- R3: A write to 0x180 with bit 31 set clears the error status (0x181) and the interrupt enable (0x182). It also clears the transmit activation words (0x184, 0x185), the receive activation words (0x190, 0x191), and the four channel status words (0x186, 0x187, 0x192, 0x193). Table pointers and buffer sizes keep their values.
- R4: The error status word (0x181) and the four channel status words are write-one-to-clear. Each written 1 clears that bit, and each written 0 leaves the bit unchanged.
- R5: Event pulses set status bits one clock edge after the pulse. Channel n of `tx_eob_evt`, `rx_eob_evt`, `tx_derr_evt` or `rx_derr_evt` sets bit 31-n of 0x186, 0x192, 0x187 or 0x193 respectively, and bit k of `err_evt` sets bit k of 0x181. An event in the same cycle as a clear of that bit leaves the bit set.
- R6: The interrupt enable keeps bits 4:0 only. The transmit activation words keep bits 31:28 only, and the receive activation words keep bits 31:30 only.
- R7: Transmit table pointers at 0x1A0+n and receive table pointers at 0x1C0+n store all 32 bits. Receive buffer sizes at 0x1E0+n keep bits 7:0 only.
- R8: Reads of an unmapped address return zero. This includes a pointer or buffer-size address at or beyond the channel count, and writes to such addresses change nothing.
- R9: The interrupt outputs are each the OR of one status word gated by one enable bit. `irq_tx_eob` uses 0x186 and enable bit 0, `irq_rx_eob` uses 0x192 and bit 1, `irq_tx_derr` uses 0x187 and bit 2, `irq_rx_derr` uses 0x193 and bit 3, and `irq_err` uses 0x181 and bit 4.
- R10: `reg_rdata` takes the addressed value on the clock edge that accepts `reg_rd_en`. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 10 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tx_eob_evt | input | TX_CH | Transmit end-of-buffer event pulses |
| rx_eob_evt | input | RX_CH | Receive end-of-buffer event pulses |
| tx_derr_evt | input | TX_CH | Transmit descriptor-error event pulses |
| rx_derr_evt | input | RX_CH | Receive descriptor-error event pulses |
| err_evt | input | 32 | Error cause pulses, bit k sets error status bit k |
| irq_tx_eob | output | 1 | Transmit end-of-buffer interrupt |
| irq_rx_eob | output | 1 | Receive end-of-buffer interrupt |
| irq_tx_derr | output | 1 | Transmit descriptor-error interrupt |
| irq_rx_derr | output | 1 | Receive descriptor-error interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Read data is due one clock edge after the cycle in which `reg_rd_en` is high. The bench therefore queues the expected word when it raises the strobe and compares it at the following falling edge. Status bits and the interrupt lines follow an event pulse or a register write after a single edge, because the interrupts are combinational from the status and enable registers. The bench drives every stimulus on a falling edge and samples the interrupts at the next falling edge. For same-cycle event and clear cases, both stimuli are driven in the same falling-edge slot so that they meet at one rising edge.

// File: rtl/dmar_pkg.sv
// Package: register addresses, writable-bit masks, reset values and helpers
// shared by the DMA channel register block. Assumes a 10-bit word address.
package dmar_pkg;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 10;
    typedef logic [DW-1:0] word_t;
    typedef logic [AW-1:0] addr_t;

    localparam addr_t A_CFG     = 10'h180;
    localparam addr_t A_ESR     = 10'h181;
    localparam addr_t A_IER     = 10'h182;
    localparam addr_t A_TX_SET  = 10'h184;
    localparam addr_t A_TX_RST  = 10'h185;
    localparam addr_t A_TX_EOB  = 10'h186;
    localparam addr_t A_TX_DERR = 10'h187;
    localparam addr_t A_RX_SET  = 10'h190;
    localparam addr_t A_RX_RST  = 10'h191;
    localparam addr_t A_RX_EOB  = 10'h192;
    localparam addr_t A_RX_DERR = 10'h193;
    localparam addr_t A_TX_PTR  = 10'h1A0;
    localparam addr_t A_RX_PTR  = 10'h1C0;
    localparam addr_t A_RX_BSZ  = 10'h1E0;

    localparam word_t CFG_RST  = 32'h0007_C000;
    localparam word_t CFG_MASK = 32'h00FF_C087;
    localparam word_t IER_MASK = 32'h0000_001F;
    localparam word_t TXA_MASK = 32'hF000_0000;
    localparam word_t RXA_MASK = 32'hC000_0000;
    localparam word_t BSZ_MASK = 32'h0000_00FF;
    localparam word_t ALL_ONES = 32'hFFFF_FFFF;
    localparam int unsigned SOFT_RST_BIT = 31;

    localparam int unsigned IE_TX_EOB  = 0;
    localparam int unsigned IE_RX_EOB  = 1;
    localparam int unsigned IE_TX_DERR = 2;
    localparam int unsigned IE_RX_DERR = 3;
    localparam int unsigned IE_ERR     = 4;

    // Moves channel n (bit n) to status position 31-n.
    function automatic word_t chan_to_status(input word_t v);
        word_t r;
        for (int i = 0; i < DW; i++) r[DW-1-i] = v[i];
        return r;
    endfunction

    // Status bits that exist for a channel count of n.
    function automatic word_t chan_mask(input int unsigned n);
        return ~(ALL_ONES >> n);
    endfunction
endpackage

// File: rtl/dmar_field_reg.sv
// Masked control register. Stores write data ANDed with MASK; a soft clear
// returns it to RST_VAL. Assumes write and soft clear never coincide for
// instances that use both (they sit at different addresses).
module dmar_field_reg
    import dmar_pkg::*;
#(
    parameter word_t RST_VAL = '0,
    parameter word_t MASK    = ALL_ONES
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  soft_clr,
    input  logic  wr_en,
    input  word_t wdata,
    output word_t q
);
    // Register update: reset, write, then soft clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= RST_VAL & MASK;
        else if (wr_en)    q <= wdata & MASK;
        else if (soft_clr) q <= RST_VAL & MASK;
    end
endmodule

// File: rtl/dmar_w1c_reg.sv
// Event status register. Bits set by set_bits pulses, cleared by writing
// ones, cleared entirely by soft clear. A set in the same cycle as any clear
// wins. Only bits in LIVE_MASK can ever be set.
module dmar_w1c_reg
    import dmar_pkg::*;
#(
    parameter word_t LIVE_MASK = ALL_ONES
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  soft_clr,
    input  logic  clr_en,
    input  word_t clr_bits,
    input  word_t set_bits,
    output word_t q
);
    word_t kept;

    // Bits that survive this cycle's clears.
    always_comb begin
        if (soft_clr)    kept = '0;
        else if (clr_en) kept = q & ~clr_bits;
        else             kept = q;
    end

    // Register update: surviving bits plus new events.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (kept | set_bits) & LIVE_MASK;
    end
endmodule

// File: rtl/dmar_ptr_bank.sv
// Array of N per-channel registers at consecutive addresses from BASE.
// Soft reset does not touch them. Provides a hit flag and the hit value for
// the read mux; addresses at or beyond BASE+N are not claimed.
module dmar_ptr_bank
    import dmar_pkg::*;
#(
    parameter int unsigned N    = 4,
    parameter addr_t       BASE = '0,
    parameter word_t       MASK = ALL_ONES
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  addr_t addr,
    input  word_t wdata,
    output logic  rd_hit,
    output word_t rd_data
);
    logic  [N-1:0] hit;
    word_t         entry [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        assign hit[i] = (addr == addr_t'(int'(BASE) + i));
        // One channel entry: cleared only by hard reset.
        always_ff @(posedge clk) begin
            if (!rst_n)               entry[i] <= '0;
            else if (wr_en && hit[i]) entry[i] <= wdata & MASK;
        end
    end

    // Read selection across entries.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++)
            if (hit[i]) rd_data = rd_data | entry[i];
    end
    assign rd_hit = |hit;
endmodule

// File: rtl/dmar_regs.sv
// DMA channel register and interrupt block. Decodes a simple synchronous
// register bus, keeps control, status and per-channel tables, and drives
// five gated interrupt lines. Assumes 1 <= TX_CH, RX_CH <= 32 and single
// cycle event pulses from the datapath.
module dmar_regs
    import dmar_pkg::*;
#(
    parameter int unsigned TX_CH = 4,
    parameter int unsigned RX_CH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_rd_en,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [TX_CH-1:0] tx_eob_evt,
    input  logic [RX_CH-1:0] rx_eob_evt,
    input  logic [TX_CH-1:0] tx_derr_evt,
    input  logic [RX_CH-1:0] rx_derr_evt,
    input  logic [DW-1:0]    err_evt,
    output logic             irq_tx_eob,
    output logic             irq_rx_eob,
    output logic             irq_tx_derr,
    output logic             irq_rx_derr,
    output logic             irq_err
);
    localparam word_t TX_LIVE = chan_mask(TX_CH);
    localparam word_t RX_LIVE = chan_mask(RX_CH);

    word_t cfg_q, esr_q, ier_q;
    word_t tx_act_set_q, tx_act_rst_q, rx_act_set_q, rx_act_rst_q;
    word_t tx_eob_st, tx_de_st, rx_eob_st, rx_de_st;
    logic  soft_clr;
    logic  txp_hit, rxp_hit, bsz_hit;
    word_t txp_val, rxp_val, bsz_val;
    word_t rd_mux;

    // Write strobe per fixed address.
    function automatic logic wr_at(input addr_t a);
        return reg_wr_en && (reg_addr == a);
    endfunction

    assign soft_clr = wr_at(A_CFG) && reg_wdata[SOFT_RST_BIT];

    dmar_field_reg #(.RST_VAL(CFG_RST), .MASK(CFG_MASK)) u_cfg (
        .clk(clk), .rst_n(rst_n), .soft_clr(1'b0), .wr_en(wr_at(A_CFG)),
        .wdata(reg_wdata), .q(cfg_q));
    dmar_field_reg #(.MASK(IER_MASK)) u_ier (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_at(A_IER)),
        .wdata(reg_wdata), .q(ier_q));
    dmar_field_reg #(.MASK(TXA_MASK)) u_tx_set (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_at(A_TX_SET)),
        .wdata(reg_wdata), .q(tx_act_set_q));
    dmar_field_reg #(.MASK(TXA_MASK)) u_tx_rst (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_at(A_TX_RST)),
        .wdata(reg_wdata), .q(tx_act_rst_q));
    dmar_field_reg #(.MASK(RXA_MASK)) u_rx_set (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_at(A_RX_SET)),
        .wdata(reg_wdata), .q(rx_act_set_q));
    dmar_field_reg #(.MASK(RXA_MASK)) u_rx_rst (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_at(A_RX_RST)),
        .wdata(reg_wdata), .q(rx_act_rst_q));

    dmar_w1c_reg #(.LIVE_MASK(ALL_ONES)) u_esr (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .clr_en(wr_at(A_ESR)),
        .clr_bits(reg_wdata), .set_bits(err_evt), .q(esr_q));
    dmar_w1c_reg #(.LIVE_MASK(TX_LIVE)) u_tx_eob (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .clr_en(wr_at(A_TX_EOB)),
        .clr_bits(reg_wdata), .set_bits(chan_to_status(word_t'(tx_eob_evt))),
        .q(tx_eob_st));
    dmar_w1c_reg #(.LIVE_MASK(TX_LIVE)) u_tx_de (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .clr_en(wr_at(A_TX_DERR)),
        .clr_bits(reg_wdata), .set_bits(chan_to_status(word_t'(tx_derr_evt))),
        .q(tx_de_st));
    dmar_w1c_reg #(.LIVE_MASK(RX_LIVE)) u_rx_eob (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .clr_en(wr_at(A_RX_EOB)),
        .clr_bits(reg_wdata), .set_bits(chan_to_status(word_t'(rx_eob_evt))),
        .q(rx_eob_st));
    dmar_w1c_reg #(.LIVE_MASK(RX_LIVE)) u_rx_de (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .clr_en(wr_at(A_RX_DERR)),
        .clr_bits(reg_wdata), .set_bits(chan_to_status(word_t'(rx_derr_evt))),
        .q(rx_de_st));

    dmar_ptr_bank #(.N(TX_CH), .BASE(A_TX_PTR), .MASK(ALL_ONES)) u_txp (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rd_hit(txp_hit), .rd_data(txp_val));
    dmar_ptr_bank #(.N(RX_CH), .BASE(A_RX_PTR), .MASK(ALL_ONES)) u_rxp (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rd_hit(rxp_hit), .rd_data(rxp_val));
    dmar_ptr_bank #(.N(RX_CH), .BASE(A_RX_BSZ), .MASK(BSZ_MASK)) u_bsz (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rd_hit(bsz_hit), .rd_data(bsz_val));

    // Read selection: fixed registers, then channel tables, else zero.
    always_comb begin
        unique case (reg_addr)
            A_CFG:     rd_mux = cfg_q;
            A_ESR:     rd_mux = esr_q;
            A_IER:     rd_mux = ier_q;
            A_TX_SET:  rd_mux = tx_act_set_q;
            A_TX_RST:  rd_mux = tx_act_rst_q;
            A_TX_EOB:  rd_mux = tx_eob_st;
            A_TX_DERR: rd_mux = tx_de_st;
            A_RX_SET:  rd_mux = rx_act_set_q;
            A_RX_RST:  rd_mux = rx_act_rst_q;
            A_RX_EOB:  rd_mux = rx_eob_st;
            A_RX_DERR: rd_mux = rx_de_st;
            default: begin
                if (txp_hit)      rd_mux = txp_val;
                else if (rxp_hit) rd_mux = rxp_val;
                else if (bsz_hit) rd_mux = bsz_val;
                else              rd_mux = '0;
            end
        endcase
    end

    // Read data register: loads on an accepted read, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         reg_rdata <= '0;
        else if (reg_rd_en) reg_rdata <= rd_mux;
    end

    assign irq_tx_eob  = ier_q[IE_TX_EOB]  && (|tx_eob_st);
    assign irq_rx_eob  = ier_q[IE_RX_EOB]  && (|rx_eob_st);
    assign irq_tx_derr = ier_q[IE_TX_DERR] && (|tx_de_st);
    assign irq_rx_derr = ier_q[IE_RX_DERR] && (|rx_de_st);
    assign irq_err     = ier_q[IE_ERR]     && (|esr_q);
endmodule

// File: rtl/dmar_regs_chk.sv
// Checker for dmar_regs: temporal properties on bus writes, events and the
// resulting register state. Attached with bind below.
module dmar_regs_chk
    import dmar_pkg::*;
#(
    parameter int unsigned TX_CH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic             reg_rd_en,
    input logic [AW-1:0]    reg_addr,
    input logic [DW-1:0]    reg_wdata,
    input logic [DW-1:0]    reg_rdata,
    input logic [TX_CH-1:0] tx_eob_evt,
    input logic [DW-1:0]    err_evt,
    input logic [DW-1:0]    cfg_q,
    input logic [DW-1:0]    esr_q,
    input logic [DW-1:0]    ier_q,
    input logic [DW-1:0]    tx_act_set_q,
    input logic [DW-1:0]    tx_eob_st
);
    p_cfg_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_CFG) |=> ((cfg_q & ~CFG_MASK) == '0));

    p_soft_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_CFG && reg_wdata[SOFT_RST_BIT])
        |=> (ier_q == '0 && tx_act_set_q == '0));

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_ESR && err_evt == '0)
        |=> ((esr_q & $past(reg_wdata)) == '0));

    p_evt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eob_evt[0] |=> tx_eob_st[DW-1]);

    p_ier_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_IER) |=> (ier_q[DW-1:5] == '0));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd_en && rst_n) |=> $stable(reg_rdata));
endmodule

bind dmar_regs dmar_regs_chk #(.TX_CH(TX_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_eob_evt(tx_eob_evt), .err_evt(err_evt), .cfg_q(cfg_q), .esr_q(esr_q),
    .ier_q(ier_q), .tx_act_set_q(tx_act_set_q), .tx_eob_st(tx_eob_st));

// File: tb/dmar_regs_tb_top.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them
// one edge later; interrupt lines are checked directly at falling edges.
module dmar_regs_tb_top;
    localparam int TX_CH = 4;
    localparam int RX_CH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [TX_CH-1:0] tx_eob_evt = '0, tx_derr_evt = '0;
    logic [RX_CH-1:0] rx_eob_evt = '0, rx_derr_evt = '0;
    logic [31:0] err_evt = '0;
    logic irq_tx_eob, irq_rx_eob, irq_tx_derr, irq_rx_derr, irq_err;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    dmar_regs #(.TX_CH(TX_CH), .RX_CH(RX_CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_eob_evt(tx_eob_evt), .rx_eob_evt(rx_eob_evt),
        .tx_derr_evt(tx_derr_evt), .rx_derr_evt(rx_derr_evt), .err_evt(err_evt),
        .irq_tx_eob(irq_tx_eob), .irq_rx_eob(irq_rx_eob),
        .irq_tx_derr(irq_tx_derr), .irq_rx_derr(irq_rx_derr), .irq_err(irq_err));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic irqs(input logic [4:0] e, input string tag);
        check(tag, {27'd0, irq_err, irq_rx_derr, irq_tx_derr, irq_rx_eob, irq_tx_eob},
              {27'd0, e});
    endtask

    // Monitor: notes accepted reads, compares the data one edge later.
    always @(posedge clk) rd_seen <= reg_rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: actual=%08h expected=none queued", reg_rdata);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        irqs(5'b00000, "R1 irqs");
        rd(10'h180, 32'h0007C000, "R1 cfg");
        rd(10'h181, 32'h0, "R1 esr");
        rd(10'h182, 32'h0, "R1 ier");
        rd(10'h186, 32'h0, "R1 txeob");
        rd(10'h1A0, 32'h0, "R1 txptr");
        // R2 config mask
        wr(10'h180, 32'hFFFFFFFF);
        rd(10'h180, 32'h00FFC087, "R2 cfg mask");
        wr(10'h180, 32'h1234_5678);
        rd(10'h180, 32'h1234_5678 & 32'h00FFC087, "R2 cfg value");
        // R6 masks
        wr(10'h182, 32'hFFFFFFFF); rd(10'h182, 32'h1F, "R6 ier");
        wr(10'h184, 32'hFFFFFFFF); rd(10'h184, 32'hF0000000, "R6 txset");
        wr(10'h185, 32'h3FFFFFFF); rd(10'h185, 32'h30000000, "R6 txrst");
        wr(10'h190, 32'hFFFFFFFF); rd(10'h190, 32'hC0000000, "R6 rxset");
        wr(10'h191, 32'h7FFFFFFF); rd(10'h191, 32'h40000000, "R6 rxrst");
        // R7 tables
        wr(10'h1A0, 32'hDEADBEEF); wr(10'h1A3, 32'h12345678);
        wr(10'h1C1, 32'hCAFEF00D); wr(10'h1E0, 32'hFFFFFFFF);
        wr(10'h1E1, 32'h00001234);
        rd(10'h1A0, 32'hDEADBEEF, "R7 txptr0");
        rd(10'h1A3, 32'h12345678, "R7 txptr3");
        rd(10'h1C1, 32'hCAFEF00D, "R7 rxptr1");
        rd(10'h1E0, 32'h000000FF, "R7 bsz0");
        rd(10'h1E1, 32'h00000034, "R7 bsz1");
        // R8 out of range and unmapped
        wr(10'h1A4, 32'h55555555);
        rd(10'h1A4, 32'h0, "R8 txptr4");
        rd(10'h1C2, 32'h0, "R8 rxptr2");
        rd(10'h1E2, 32'h0, "R8 bsz2");
        rd(10'h183, 32'h0, "R8 hole");
        rd(10'h1A3, 32'h12345678, "R8 neighbour kept");
        // R5 events
        @(negedge clk);
        tx_eob_evt = 4'b0101; rx_eob_evt = 2'b10; tx_derr_evt = 4'b1000;
        rx_derr_evt = 2'b01; err_evt = 32'h11;
        @(negedge clk);
        tx_eob_evt = '0; rx_eob_evt = '0; tx_derr_evt = '0; rx_derr_evt = '0; err_evt = '0;
        irqs(5'b11111, "R9 all pending");
        rd(10'h186, 32'hA0000000, "R5 txeob");
        rd(10'h192, 32'h40000000, "R5 rxeob");
        rd(10'h187, 32'h10000000, "R5 txderr");
        rd(10'h193, 32'h80000000, "R5 rxderr");
        rd(10'h181, 32'h00000011, "R5 esr");
        // R4 write-one-to-clear
        wr(10'h186, 32'h80000000); rd(10'h186, 32'h20000000, "R4 txeob partial");
        irqs(5'b11111, "R9 still pending");
        wr(10'h186, 32'h20000000); rd(10'h186, 32'h0, "R4 txeob clear");
        irqs(5'b11110, "R9 txeob dropped");
        wr(10'h181, 32'h00000001); rd(10'h181, 32'h10, "R4 esr partial");
        // R9 gating
        wr(10'h182, 32'h00000002);
        irqs(5'b00010, "R9 gate");
        // R4 and R5 clear versus same-cycle event
        wr(10'h192, 32'h40000000); rd(10'h192, 32'h0, "R4 rxeob clear");
        irqs(5'b00000, "R9 rxeob dropped");
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 10'h192; reg_wdata = 32'h40000000; rx_eob_evt = 2'b10;
        @(negedge clk);
        reg_wr_en = 1'b0; rx_eob_evt = '0;
        rd(10'h192, 32'h40000000, "R5 event beats clear");
        irqs(5'b00010, "R9 event raises");
        // R3 soft reset
        wr(10'h180, 32'h80000000);
        irqs(5'b00000, "R3 irqs");
        rd(10'h180, 32'h0, "R3 cfg");
        rd(10'h181, 32'h0, "R3 esr");
        rd(10'h182, 32'h0, "R3 ier");
        rd(10'h184, 32'h0, "R3 txset");
        rd(10'h191, 32'h0, "R3 rxrst");
        rd(10'h187, 32'h0, "R3 txderr");
        rd(10'h192, 32'h0, "R3 rxeob");
        rd(10'h193, 32'h0, "R3 rxderr");
        rd(10'h1C1, 32'hCAFEF00D, "R3 rxptr kept");
        rd(10'h1A0, 32'hDEADBEEF, "R3 txptr kept");
        rd(10'h1E0, 32'h000000FF, "R3 bsz kept");
        // R10 hold
        repeat (3) @(negedge clk);
        check("R10 hold", reg_rdata, 32'h000000FF);
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R10: actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule